// File: doc/BRIEF.md
# Refresh Request Watermark Generator

This block tells a DRAM command scheduler when refreshes are owed and how urgent they are. A down-counter in the memory clock domain marks out refresh intervals of a programmable length. Each finished interval adds one to a small count of refreshes still owed. The scheduler answers with a one-cycle grant for every refresh it carries out, and each grant takes one off that count.

Two urgency flags are compared against the owed count. Each flag has its own 2-bit watermark selector. The low-urgency flag means refreshes can be slipped in when the bus is idle. The high-urgency flag means they must be forced soon. A single request output is raised while either flag is up. Command timing and rank selection are handled elsewhere.

Top module: `refresh_wm_gen`

## Requirements
- R1: An active-low asynchronous reset clears the owed count, so `urg_low`, `urg_high` and `ref_req` are 0. The interval counter starts from the parameter `DEF_TIMEOUT` (default 0xC30, which is 7.8 us at 400 MHz), so the first expiry comes `DEF_TIMEOUT` clocks after reset is released.
- R2: After the first expiry, expiries occur every `tmo_val` clocks. Each expiry with no grant in the same cycle raises the owed count by one, visible after that clock edge. Values of 0 and 1 both give an expiry on every clock.
- R3: `urg_low` is 1 exactly when the owed count is greater than the low threshold. The `low_sel` encoding is 0 → 1, 1 → 2, 2 → 3, 3 → 4.
- R4: `urg_high` is 1 exactly when the owed count is greater than the high threshold. The `high_sel` encoding is 0 → 3, 1 → 4, 2 → 5, 3 → 6.
- R5: `ref_req` is 1 whenever `urg_low` or `urg_high` is 1, and 0 otherwise. The flags follow the current count and the current selectors with no added cycle of delay.
- R6: The owed count saturates at 7. Further expiries leave it at 7.
- R7: A grant with no expiry in the same cycle lowers the owed count by one. A grant while the count is 0 has no effect.
- R8: An expiry and a grant in the same cycle leave the owed count unchanged.
- R9: A new `tmo_val` is sampled only when the counter reloads. The interval already in progress finishes with its old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tmo_val | input | 14 | Refresh interval length in clocks, sampled at each reload |
| low_sel | input | 2 | Low-urgency watermark selector |
| high_sel | input | 2 | High-urgency watermark selector |
| ref_grant | input | 1 | One pulse per refresh the scheduler completed |
| ref_req | output | 1 | Refresh request to the scheduler |
| urg_low | output | 1 | Owed count is above the low watermark |
| urg_high | output | 1 | Owed count is above the high watermark |

## Verification
The checker assumes that `ref_grant` and the selectors are synchronous to `clk` and hold known values once reset is released. It also assumes a grant may arrive at any time, including when nothing is owed. The bench changes every input only at the falling edge. It holds a grant high over several rising edges on purpose, so that it reaches the zero floor and lands in the same cycle as an expiry. It reads the flags only half a clock after the rising edge it is testing.

// File: rtl/refresh_wm_pkg.sv
package refresh_wm_pkg;
   localparam int WM_SEL_W = 2;
   typedef logic [WM_SEL_W-1:0] wm_sel_t;
   typedef enum int {FLG_LOW = 0, FLG_HIGH = 1} flag_idx_e;
   localparam int N_FLAGS = 2;
endpackage

// File: rtl/rf_interval_timer.sv
module rf_interval_timer #(
   parameter int TW          = 14,
   parameter int DEF_TIMEOUT = 'hC30
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [TW-1:0] tmo_val,
   output logic          expire
);
   localparam logic [TW-1:0] DEF_W = TW'(DEF_TIMEOUT);

   logic [TW-1:0] cnt_q;
   logic          hit;

   assign hit    = (cnt_q <= TW'(1));
   assign expire = hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= DEF_W;
      else if (hit) cnt_q <= tmo_val;
      else          cnt_q <= cnt_q - TW'(1);
   end
endmodule

// File: rtl/rf_pending_ctr.sv
module rf_pending_ctr #(
   parameter int CW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   input  logic          dec,
   output logic [CW-1:0] count
);
   localparam logic [CW-1:0] CMAX = {CW{1'b1}};

   logic [CW-1:0] cnt_q;
   assign count = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         case ({inc, dec})
            2'b10:   if (cnt_q != CMAX) cnt_q <= cnt_q + CW'(1);
            2'b01:   if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end
endmodule

// File: rtl/rf_wm_compare.sv
module rf_wm_compare
   import refresh_wm_pkg::*;
#(
   parameter int CW   = 3,
   parameter int BASE = 1
) (
   input  logic [CW-1:0] count,
   input  wm_sel_t       sel,
   output logic          above
);
   localparam logic [CW:0] BASE_W = (CW+1)'(BASE);

   logic [CW:0] thr;
   assign thr   = BASE_W + {{(CW+1-WM_SEL_W){1'b0}}, sel};
   assign above = ({1'b0, count} > thr);
endmodule

// File: rtl/refresh_wm_gen.sv
module refresh_wm_gen
   import refresh_wm_pkg::*;
#(
   parameter int TW          = 14,
   parameter int CW          = 3,
   parameter int DEF_TIMEOUT = 'hC30,
   parameter int LOW_BASE    = 1,
   parameter int HIGH_BASE   = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [TW-1:0] tmo_val,
   input  logic [1:0]    low_sel,
   input  logic [1:0]    high_sel,
   input  logic          ref_grant,
   output logic          ref_req,
   output logic          urg_low,
   output logic          urg_high
);
   localparam int CMAX   = (1 << CW) - 1;
   localparam int SEL_MX = (1 << WM_SEL_W) - 1;

   if (TW < 2) begin : g_bad_tw
      $error("refresh_wm_gen: TW must be at least 2");
   end
   if (DEF_TIMEOUT >= (1 << TW)) begin : g_bad_def
      $error("refresh_wm_gen: DEF_TIMEOUT does not fit in TW bits");
   end
   if (LOW_BASE + SEL_MX >= CMAX) begin : g_bad_low
      $error("refresh_wm_gen: low watermark unreachable with CW bits");
   end
   if (HIGH_BASE + SEL_MX >= CMAX) begin : g_bad_high
      $error("refresh_wm_gen: high watermark unreachable with CW bits");
   end

   logic          tick;
   logic [CW-1:0] pend_cnt;
   logic [N_FLAGS-1:0] flag;

   rf_interval_timer #(.TW(TW), .DEF_TIMEOUT(DEF_TIMEOUT)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .tmo_val (tmo_val),
      .expire  (tick)
   );

   rf_pending_ctr #(.CW(CW)) u_pend (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (tick),
      .dec   (ref_grant),
      .count (pend_cnt)
   );

   for (genvar g = 0; g < N_FLAGS; g++) begin : g_wm
      localparam int BASE_G = (g == int'(FLG_LOW)) ? LOW_BASE : HIGH_BASE;
      wm_sel_t sel_g;
      assign sel_g = (g == int'(FLG_LOW)) ? low_sel : high_sel;
      rf_wm_compare #(.CW(CW), .BASE(BASE_G)) u_cmp (
         .count (pend_cnt),
         .sel   (sel_g),
         .above (flag[g])
      );
   end

   assign urg_low  = flag[FLG_LOW];
   assign urg_high = flag[FLG_HIGH];
   assign ref_req  = |flag;
endmodule

// File: rtl/refresh_wm_chk.sv
module refresh_wm_chk #(
   parameter int CW = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          grant,
   input logic          expire,
   input logic [CW-1:0] pend,
   input logic          low,
   input logic          high,
   input logic          req
);
   localparam logic [CW-1:0] CMAX = {CW{1'b1}};

   a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!req && !low && !high));

   a_r2_expiry_counts: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !grant && pend != CMAX) |=> (pend == $past(pend) + CW'(1)));

   a_r3_low_needs_two: assert property (@(posedge clk) disable iff (!rst_n)
      low |-> (pend >= CW'(2)));

   a_r4_high_needs_four: assert property (@(posedge clk) disable iff (!rst_n)
      high |-> (pend >= CW'(4)));

   a_r5_flag_raises_req: assert property (@(posedge clk) disable iff (!rst_n)
      (low || high) |-> req);

   a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      (pend == CMAX && expire && !grant) |=> (pend == CMAX));

   a_r7_grant_takes_one: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && !expire && pend != '0) |=> (pend == $past(pend) - CW'(1)));

   a_r7_floor_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && !expire && pend == '0) |=> (pend == '0));

   a_r8_both_cancel: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && expire) |=> $stable(pend));
endmodule

bind refresh_wm_gen refresh_wm_chk #(.CW(CW)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .grant  (ref_grant),
   .expire (tick),
   .pend   (pend_cnt),
   .low    (urg_low),
   .high   (urg_high),
   .req    (ref_req)
);

// File: tb/refresh_wm_gen_bench.sv
`timescale 1ns/1ps
module refresh_wm_gen_bench;
   localparam int TW  = 14;
   localparam int DEF = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [TW-1:0] tmo_val = TW'(8);
   logic [1:0]    low_sel = 2'd0;
   logic [1:0]    high_sel = 2'd0;
   logic          ref_grant = 1'b0;
   logic          ref_req, urg_low, urg_high;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   refresh_wm_gen #(.TW(TW), .CW(3), .DEF_TIMEOUT(DEF)) u_refresh_wm_gen (
      .clk (clk), .rst_n (rst_n), .tmo_val (tmo_val),
      .low_sel (low_sel), .high_sel (high_sel), .ref_grant (ref_grant),
      .ref_req (ref_req), .urg_low (urg_low), .urg_high (urg_high)
   );

   // row: [13:6] edges to advance, [5:4] low_sel, [3:2] high_sel, [1] urg_low, [0] urg_high
   localparam logic [13:0] VEC [9] = '{
      {8'd8,  2'd0, 2'd0, 1'b0, 1'b0},  // count 1: R2 R3
      {8'd8,  2'd0, 2'd0, 1'b1, 1'b0},  // count 2: R3
      {8'd0,  2'd1, 2'd0, 1'b0, 1'b0},  // count 2, low thr 2: R3
      {8'd8,  2'd1, 2'd0, 1'b1, 1'b0},  // count 3, high thr 3: R4
      {8'd8,  2'd3, 2'd0, 1'b0, 1'b1},  // count 4: R4 high alone
      {8'd16, 2'd3, 2'd2, 1'b1, 1'b1},  // count 6: R3 R4
      {8'd0,  2'd3, 2'd3, 1'b1, 1'b0},  // count 6, high thr 6: R4
      {8'd8,  2'd3, 2'd3, 1'b1, 1'b1},  // count 7: R4
      {8'd24, 2'd3, 2'd3, 1'b1, 1'b1}   // saturated: R6
   };

   task automatic check(string tag, logic act, logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step(int n);
      if (n == 0) #1;
      else begin
         repeat (n) @(posedge clk);
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset req", ref_req, 1'b0);
      check("R1 reset low", urg_low, 1'b0);
      check("R1 reset high", urg_high, 1'b0);
      rst_n = 1'b1;

      for (int i = 0; i < 9; i++) begin
         logic [13:0] row;
         row      = VEC[i];
         low_sel  = row[5:4];
         high_sel = row[3:2];
         step(int'(row[13:6]));
         check("R3 table low", urg_low, row[1]);
         check("R4 table high", urg_high, row[0]);
         check("R5 table req", ref_req, row[1] | row[0]);
      end

      // edge 80 done, count 7
      ref_grant = 1'b1; step(1); ref_grant = 1'b0;
      check("R6 saturated then one grant", urg_high, 1'b0);
      check("R7 one grant low", urg_low, 1'b1);
      low_sel = 2'd0; high_sel = 2'd0;
      ref_grant = 1'b1; step(4); ref_grant = 1'b0;   // count 2 after edge 85
      check("R7 grants low", urg_low, 1'b1);
      check("R7 grants high", urg_high, 1'b0);
      step(2);                                       // edge 87
      ref_grant = 1'b1; step(1); ref_grant = 1'b0;   // edge 88 expiry + grant
      check("R8 both lowsel0", urg_low, 1'b1);
      low_sel = 2'd1; step(0);
      check("R8 both lowsel1", urg_low, 1'b0);
      low_sel = 2'd0;
      ref_grant = 1'b1; step(3); ref_grant = 1'b0;   // edges 89..91, count 0
      check("R7 drained req", ref_req, 1'b0);
      step(5);                                       // edge 96, count 1
      check("R7 floor count1 low", urg_low, 1'b0);
      check("R7 floor count1 high", urg_high, 1'b0);
      step(8);                                       // edge 104, count 2
      check("R7 floor count2 low", urg_low, 1'b1);
      check("R7 floor count2 high", urg_high, 1'b0);

      tmo_val = TW'(3); low_sel = 2'd1;
      step(7);                                       // edge 111
      check("R9 old interval still running", urg_low, 1'b0);
      step(1);                                       // edge 112, count 3
      check("R9 old interval expiry", urg_low, 1'b1);
      step(2);                                       // edge 114
      check("R2 new interval not yet", urg_high, 1'b0);
      step(1);                                       // edge 115, count 4
      check("R2 new interval expiry", urg_high, 1'b1);

      rst_n = 1'b0; step(0);
      check("R1 async clear req", ref_req, 1'b0);
      check("R1 async clear high", urg_high, 1'b0);
      step(2);
      low_sel = 2'd0; high_sel = 2'd0;
      rst_n = 1'b1;
      step(10);                                      // expiry at edge 8 only
      check("R1 first interval uses default", urg_low, 1'b0);
      step(1);                                       // edge 11, count 2
      check("R1 then programmed interval", urg_low, 1'b1);
      check("R5 req follows low", ref_req, 1'b1);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule